// File: doc/BRIEF.md
# Channel Enable Mask Command Registers

This block keeps a per-channel enable mask of up to 64 bits, the kind of mask that gates DMA request inputs or error-interrupt sources. Software never writes the mask directly. It writes one-byte commands into two write-only command registers. One register turns channels on and the other turns them off. A single channel can change without a read-modify-write, so two agents that touch different channels cannot race each other.

Each command byte has a skip flag in its most significant bit and a 7-bit channel code below it. A code of 64 or more acts on every implemented channel at once. The set register and the clear register are adjacent bytes in one bus word. One 32-bit write with both byte strobes can therefore carry two independent commands. A lane whose skip flag is 1, or whose strobe is low, does nothing. The mask is visible on a 64-bit output and can be read back as two 32-bit status words.

Top module: `chan_enable_cmd_regs`

## Requirements
- R1: A synchronous active-high reset sets the whole mask to zero, so both status words read zero.
- R2: In a command byte, bit 7 is the skip flag and bits 6:0 are the channel code. A byte with bit 7 = 1 changes nothing.
- R3: A set command whose code is below NUM_CH sets that one mask bit and leaves all other bits unchanged.
- R4: A clear command whose code is below NUM_CH clears that one mask bit and leaves all other bits unchanged.
- R5: A set command with a code from 64 to 127 sets every implemented mask bit. A clear command with such a code clears every mask bit.
- R6: A code from NUM_CH to 63 has no effect. Mask bits at or above NUM_CH always stay zero.
- R7: Commands are taken only on a write to byte address 0x18. The set command is the byte on wdata[31:24] under strobe be[3] (offset 0x18). The clear command is the byte on wdata[23:16] under strobe be[2] (offset 0x19). A lane without its strobe is ignored. Lanes be[1] and be[0] of this word have no effect.
- R8: Both lanes of one write take effect on the same clock edge. The set is applied first and the clear second, so a clear wins over a set on the same channel.
- R9: The read data is combinational on the address. 0x00 returns mask[63:32], 0x04 returns mask[31:0], and the command word 0x18 and every other address return zero.
- R10: The mask holds its value in any cycle without a write to 0x18. This includes a write to another address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access (word aligned) |
| bus_we | input | 1 | Write qualifier for this cycle |
| bus_be | input | 4 | Byte strobes; be[3] selects wdata[31:24] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| mask_o | output | 64 | Channel enable mask |

## Verification
The bench targets single writes that carry both a set and a clear. A design that applied them in the wrong order would leave the channel enabled, and one that dropped a lane would lose half of the packed command. The bench uses a channel count below 64. A decoder that forgot the range limit would then raise bits above the implemented channels for codes 48 to 63, or fill the whole word on a global set. Skip flags, missing strobes, the two unused lanes and writes to other addresses must leave the mask untouched. A decoder that looked only at the data byte would corrupt the mask in those cases.

// File: rtl/chmask_pkg.sv
package chmask_pkg;

    localparam int MASK_W = 64;
    localparam int BUS_W  = 32;
    localparam int LANES  = BUS_W / 8;
    localparam int CODE_W = 7;

    localparam logic [7:0] OFS_STAT_HI = 8'h00;
    localparam logic [7:0] OFS_STAT_LO = 8'h04;
    localparam logic [7:0] OFS_CMD     = 8'h18;

    typedef enum logic [1:0] {
        LANE_SET  = 2'd0,
        LANE_CLR  = 2'd1,
        LANE_NONE = 2'd2
    } lane_kind_e;

    typedef struct packed {
        logic              skip;
        logic [CODE_W-1:0] code;
    } cmd_byte_t;

    typedef struct packed {
        logic [MASK_W-1:0] set_v;
        logic [MASK_W-1:0] clr_v;
    } mask_upd_t;

    // Lane 3 carries the byte at offset 0x18, lane 2 the byte at 0x19.
    function automatic lane_kind_e kind_of_lane(input int lane);
        if (lane == LANES - 1)      return LANE_SET;
        else if (lane == LANES - 2) return LANE_CLR;
        else                        return LANE_NONE;
    endfunction

    function automatic logic [MASK_W-1:0] impl_mask(input int num_ch);
        logic [MASK_W-1:0] v;
        for (int i = 0; i < MASK_W; i++) v[i] = (i < num_ch);
        return v;
    endfunction

    function automatic logic [MASK_W-1:0] code_to_vec(input logic [CODE_W-1:0] code,
                                                      input int num_ch);
        logic [MASK_W-1:0] v;
        for (int i = 0; i < MASK_W; i++) begin
            if (code[CODE_W-1]) v[i] = (i < num_ch);
            else                v[i] = (i < num_ch) && (int'(code) == i);
        end
        return v;
    endfunction

endpackage

// File: rtl/chmask_lane_dec.sv
module chmask_lane_dec
    import chmask_pkg::*;
#(
    parameter int         NUM_CH = 64,
    parameter lane_kind_e KIND   = LANE_NONE
) (
    input  logic              lane_en,
    input  logic [7:0]        lane_byte,
    output logic [MASK_W-1:0] set_v,
    output logic [MASK_W-1:0] clr_v
);
    cmd_byte_t         cmd;
    logic              active;
    logic [MASK_W-1:0] hit;

    always_comb begin
        cmd    = cmd_byte_t'(lane_byte);
        active = lane_en && !cmd.skip;
        hit    = code_to_vec(cmd.code, NUM_CH);
        set_v  = '0;
        clr_v  = '0;
        if (active) begin
            case (KIND)
                LANE_SET: set_v = hit;
                LANE_CLR: clr_v = hit;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/chmask_store.sv
module chmask_store
    import chmask_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  mask_upd_t         upd,
    output logic [MASK_W-1:0] mask_q
);
    localparam logic [MASK_W-1:0] IMPL = impl_mask(NUM_CH);

    logic [MASK_W-1:0] after_set;
    logic [MASK_W-1:0] mask_d;

    always_comb begin
        after_set = mask_q | upd.set_v;
        mask_d    = after_set & ~upd.clr_v & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/chmask_rdmux.sv
module chmask_rdmux
    import chmask_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    output logic [BUS_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFS_STAT_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFS_STAT_LO);

    always_comb begin
        if (addr == A_HI)      rdata = mask[MASK_W-1:BUS_W];
        else if (addr == A_LO) rdata = mask[BUS_W-1:0];
        else                   rdata = '0;
    end
endmodule

// File: rtl/chan_enable_cmd_regs.sv
module chan_enable_cmd_regs
    import chmask_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [63:0]       mask_o
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);

    logic              cmd_hit;
    logic [MASK_W-1:0] lane_set [LANES];
    logic [MASK_W-1:0] lane_clr [LANES];
    mask_upd_t         upd;
    logic [MASK_W-1:0] mask_q;

    assign cmd_hit = bus_we && (bus_addr == A_CMD);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        chmask_lane_dec #(
            .NUM_CH (NUM_CH),
            .KIND   (kind_of_lane(g))
        ) u_dec (
            .lane_en   (cmd_hit && bus_be[g]),
            .lane_byte (bus_wdata[8*g +: 8]),
            .set_v     (lane_set[g]),
            .clr_v     (lane_clr[g])
        );
    end

    always_comb begin
        upd = '0;
        for (int i = 0; i < LANES; i++) begin
            upd.set_v = upd.set_v | lane_set[i];
            upd.clr_v = upd.clr_v | lane_clr[i];
        end
    end

    chmask_store #(.NUM_CH(NUM_CH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .mask_q (mask_q)
    );

    chmask_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .addr  (bus_addr),
        .mask  (mask_q),
        .rdata (bus_rdata)
    );

    assign mask_o = mask_q;
endmodule

// File: rtl/chmask_checker.sv
module chmask_checker
    import chmask_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [63:0]       mask_o
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
    localparam logic [63:0]       IMPL  = impl_mask(NUM_CH);

    logic cmd_wr, set_live, clr_live;
    assign cmd_wr   = bus_we && (bus_addr == A_CMD);
    assign set_live = cmd_wr && bus_be[3] && !bus_wdata[31];
    assign clr_live = cmd_wr && bus_be[2] && !bus_wdata[23];

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mask_o & ~IMPL) == '0); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> mask_o == $past(mask_o)); // R10
    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !set_live && !clr_live) |=> $stable(mask_o)); // R2
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (clr_live && bus_wdata[22]) |=> mask_o == '0); // R5
    AST_SET_ALL: assert property (@(posedge clk) disable iff (rst)
        (set_live && bus_wdata[30] && !clr_live) |=> mask_o == IMPL); // R5
    AST_SET_ONE: assert property (@(posedge clk) disable iff (rst)
        (set_live && !bus_wdata[30] && (int'(bus_wdata[29:24]) < NUM_CH) && !clr_live)
        |=> mask_o[$past(bus_wdata[29:24])]); // R3
    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CMD) |-> bus_rdata == '0); // R9
endmodule

bind chan_enable_cmd_regs chmask_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_o    (mask_o)
);

// File: tb/chan_enable_cmd_regs_bench.sv
module chan_enable_cmd_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] mask_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] model = '0;
    logic [63:0] impl;
    string       cur_req = "R1";
    bit          running = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_enable_cmd_regs #(.NUM_CH(NCH), .ADDR_W(8)) u_chan_enable_cmd_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mask_o(mask_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_code(input int c, input bit do_set);
        if (c >= 64)       model = do_set ? impl : 64'd0;
        else if (c < NCH)  model[c] = do_set;
    endtask

    task automatic model_apply(input logic [7:0] a, input logic [3:0] be,
                               input logic [31:0] d, input logic we);
        if (we && a == 8'h18) begin
            if (be[3] && !d[31]) model_code(int'(d[30:24]), 1'b1);
            if (be[2] && !d[23]) model_code(int'(d[22:16]), 1'b0);
        end
    endtask

    task automatic bus_cycle(input string req, input logic [7:0] a, input logic we,
                             input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cur_req = req;
        bus_addr = a; bus_we = we; bus_be = be; bus_wdata = d;
        @(posedge clk);
        model_apply(a, be, d, we);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0; bus_addr = 8'hFF;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(req, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (running && !rst) chk({cur_req, " mask"}, mask_o, model);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        impl = '0;
        for (int i = 0; i < NCH; i++) impl[i] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        running = 1'b1;
        // R1 reset state
        chk("R1 reset", mask_o, 64'd0);
        rd_chk("R1 hi", 8'h00, 32'd0);
        rd_chk("R1 lo", 8'h04, 32'd0);
        // R3 single sets
        bus_cycle("R3", 8'h18, 1'b1, 4'b1000, 32'h0500_0000);
        bus_cycle("R3", 8'h18, 1'b1, 4'b1000, 32'h2800_0000);
        bus_cycle("R3", 8'h18, 1'b1, 4'b1000, 32'h2F00_0000);
        chk("R3 ch40", {63'd0, mask_o[40]}, 64'd1);
        rd_chk("R9 hi", 8'h00, model[63:32]);
        rd_chk("R9 lo", 8'h04, model[31:0]);
        rd_chk("R9 cmd", 8'h18, 32'd0);
        rd_chk("R9 other", 8'h08, 32'd0);
        // R4 single clear
        bus_cycle("R4", 8'h18, 1'b1, 4'b0100, 32'h0005_0000);
        chk("R4 ch5", {63'd0, mask_o[5]}, 64'd0);
        // R2 skip flag
        bus_cycle("R2", 8'h18, 1'b1, 4'b1100, 32'h8728_0000);
        chk("R2 skip", mask_o, model);
        // R7 missing strobe, unused lanes
        bus_cycle("R7", 8'h18, 1'b1, 4'b0011, 32'h0700_0707);
        bus_cycle("R7", 8'h18, 1'b1, 4'b0100, 32'h0700_0000);
        chk("R7 lanes", {63'd0, mask_o[7]}, 64'd0);
        // R6 unimplemented codes
        bus_cycle("R6", 8'h18, 1'b1, 4'b1000, 32'h3200_0000);
        bus_cycle("R6", 8'h18, 1'b1, 4'b1000, 32'h3F00_0000);
        chk("R6 hi bits", mask_o & ~impl, 64'd0);
        // R10 non-writes
        bus_cycle("R10", 8'h18, 1'b0, 4'b1000, 32'h0900_0000);
        bus_cycle("R10", 8'h00, 1'b1, 4'b1111, 32'h0909_0909);
        bus_cycle("R10", 8'h1C, 1'b1, 4'b1111, 32'h0909_0909);
        chk("R10 ch9", {63'd0, mask_o[9]}, 64'd0);
        // R5 global set and clear
        bus_cycle("R5", 8'h18, 1'b1, 4'b1000, 32'h4000_0000);
        chk("R5 set all", mask_o, impl);
        bus_cycle("R5", 8'h18, 1'b1, 4'b0100, 32'h007F_0000);
        chk("R5 clr all", mask_o, 64'd0);
        // R8 packed set + clear
        bus_cycle("R8", 8'h18, 1'b1, 4'b1100, 32'h6403_0000);
        chk("R8 global set then clear one", mask_o, impl & ~(64'd1 << 3));
        bus_cycle("R8", 8'h18, 1'b1, 4'b1100, 32'h0303_0000);
        chk("R8 same channel clear wins", {63'd0, mask_o[3]}, 64'd0);
        bus_cycle("R8", 8'h18, 1'b1, 4'b1100, 32'h1103_0000);
        chk("R8 two channels", {62'd0, mask_o[17], mask_o[3]}, 64'd2);
        bus_cycle("R8", 8'h18, 1'b1, 4'b1100, 32'h7F40_0000);
        chk("R8 global both", mask_o, 64'd0);
        // Mixed pseudo-random traffic, compared every clock
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = lfsr;
            if (d[0]) d[30] = 1'b0;
            if (d[1]) d[22] = 1'b0;
            bus_cycle("R8 mix", d[3] ? 8'h18 : 8'h04, 1'b1, lfsr[7:4] | 4'b0100, d);
        end
        rd_chk("R9 final hi", 8'h00, model[63:32]);
        rd_chk("R9 final lo", 8'h04, model[31:0]);
        // R1 reset again
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        model = '0;
        chk("R1 re-reset", mask_o, 64'd0);
        running = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule